// File: doc/BRIEF.md
# Page Write Timer and Toggle-Poll Unit

This block sits between a host bus and a small nonvolatile-style array that is split into two planes by its top address bit. A write strobe opens a page, and later strobes to the same page (every address bit above the 5-bit byte offset equal) add bytes to a page buffer. A page holds 1 to 32 bytes. Every accepted byte restarts a byte-load window. When that window runs out with no new byte, the buffered page is copied into the array during a modelled programming time. The load window and the programming time are parameters counted in clock cycles.

While a page is loading or programming, the plane that holds it is busy. A read of the busy plane returns a status byte instead of array contents. The poll bit of that status byte flips on every poll. A read of the other plane returns true array contents, so a host can keep fetching code from one plane while the other is written. A write-control input that is raised while a page is still loading throws the page away. A busy output and a one-cycle done pulse show the progress of each page.

Top module: `pwt_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are low.
- R2: With `wr_ctl` low, a write strobe while idle opens a page, and `busy` is high from the next cycle. Strobes to the same page (address bits 9:5 equal) are collected, up to 32 offsets. A second strobe to an offset already in the buffer replaces the earlier byte.
- R3: Each accepted byte restarts the load window. Programming starts LOAD_CYC cycles after the last accepted byte and lasts PROG_CYC cycles. `done` is then high for exactly one cycle, and `busy` falls in the same cycle.
- R4: After `done`, reads return the bytes of the page at the offsets that were written. Offsets of that page that were not written keep their previous contents. The array changes only during programming.
- R5: A read whose address bit 9 equals the plane of the open page, while `busy` is high, returns a status byte. Bit 6 of that byte is 0 on the first poll of the page and inverts on each later poll, through both loading and programming. Bits 7 and 5:0 are those of the last accepted byte.
- R6: A read of the other plane while `busy` is high returns the stored array data.
- R7: During loading, a strobe to a different page is ignored. Nothing is buffered or programmed, and the last-byte status is unchanged.
- R8: A strobe during programming is ignored. The array and the status bits are unaffected.
- R9: Raising `wr_ctl` during loading discards the page. `busy` drops at the next cycle, no `done` follows, and the array is unchanged.
- R10: A write strobe while idle with `wr_ctl` high is ignored, and no page opens.
- R11: Every read gives `rd_valid` and `rdata` exactly one cycle after `rd_en`. `rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctl | input | 1 | Write control: blocks new pages and aborts a loading page |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (10) | Byte address; the top bit selects the plane |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data or poll status |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | A page is loading or programming |
| done | output | 1 | One-cycle pulse when programming ends |

## Verification
Read results are due one cycle after the strobe. `busy` rises one cycle after the first accepted byte and falls one cycle after an abort. `done` is due LOAD_CYC + PROG_CYC edges after the last accepted byte. The bench drives and samples on falling edges. It counts edges from the strobe to each of these points and checks the level just before and just after the expected edge. Read results go into a queue when the read is issued, and they are compared in order as `rd_valid` shows them. A result with no pending entry is a latency error.

// File: rtl/pwt_pkg.sv
// Shared types for the page write timer and toggle-poll unit.
package pwt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;
endpackage

// File: rtl/pwt_page_buf.sv
// Page buffer: one data byte and one valid flag for each page offset.
// Assumes start, load and clear are never raised in the same cycle.
module pwt_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [OFF_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    logic [PAGE_BYTES-1:0] vld_q;
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = (off_i == OFF_W'(g));

        // Valid flag: set by a store, cleared on page open or clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       vld_q[g] <= 1'b0;
            else if (clear_i) vld_q[g] <= 1'b0;
            else if (start_i) vld_q[g] <= hit;
            else if (load_i && hit) vld_q[g] <= 1'b1;
        end

        // Data byte: captured on every store to this offset.
        always_ff @(posedge clk) begin
            if (!rst_n)                       slot_q[g] <= '0;
            else if ((start_i || load_i) && hit) slot_q[g] <= data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
    assign rd_vld_o  = vld_q[rd_idx_i];

    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (vld_q == '0));
endmodule

// File: rtl/pwt_array.sv
// Behavioural byte array with combinational read and one write port.
// Contents are not reset; only programmed locations are defined.
module pwt_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pwt_sequencer.sv
// Phase control: idle, page load with a restartable window, and a timed
// programming phase that walks the buffer offsets one per cycle.
// Assumes PROG_CYC >= PAGE_BYTES so every offset is visited.
module pwt_sequencer
    import pwt_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int LOAD_CYC   = 20,
    parameter int PROG_CYC   = 48,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_ctl_i,
    input  logic             page_match_i,
    output phase_t           phase_o,
    output logic             start_o,
    output logic             load_o,
    output logic             clear_o,
    output logic             prog_act_o,
    output logic [OFF_W-1:0] prog_idx_o,
    output logic             done_o
);
    localparam int LW = $clog2(LOAD_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam int IW = $clog2(PAGE_BYTES + 1);
    localparam logic [LW-1:0] LD_RELOAD = LW'(LOAD_CYC - 1);
    localparam logic [PW-1:0] PG_RELOAD = PW'(PROG_CYC - 1);
    localparam logic [IW-1:0] IDX_END   = IW'(PAGE_BYTES);

    phase_t        phase_q;
    logic [LW-1:0] ld_cnt_q;
    logic [PW-1:0] pg_cnt_q;
    logic [IW-1:0] idx_q;
    logic          done_q;

    initial begin
        assert_prog_len_R4: assert (PROG_CYC >= PAGE_BYTES);
    end

    assign start_o    = (phase_q == PH_IDLE) && wr_en_i && !wr_ctl_i;
    assign load_o     = (phase_q == PH_LOAD) && wr_en_i && !wr_ctl_i && page_match_i;
    assign clear_o    = ((phase_q == PH_LOAD) && wr_ctl_i) ||
                        ((phase_q == PH_PROG) && (pg_cnt_q == '0));
    assign prog_act_o = (phase_q == PH_PROG) && (idx_q < IDX_END);
    assign prog_idx_o = idx_q[OFF_W-1:0];
    assign phase_o    = phase_q;
    assign done_o     = done_q;

    // Phase transitions, load window, programming timer and offset walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            ld_cnt_q <= '0;
            pg_cnt_q <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_o) begin
                        phase_q  <= PH_LOAD;
                        ld_cnt_q <= LD_RELOAD;
                    end
                end
                PH_LOAD: begin
                    if (wr_ctl_i) begin
                        phase_q <= PH_IDLE;
                    end else if (load_o) begin
                        ld_cnt_q <= LD_RELOAD;
                    end else if (ld_cnt_q == '0) begin
                        phase_q  <= PH_PROG;
                        pg_cnt_q <= PG_RELOAD;
                        idx_q    <= '0;
                    end else begin
                        ld_cnt_q <= ld_cnt_q - 1'b1;
                    end
                end
                PH_PROG: begin
                    if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
                    if (pg_cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        pg_cnt_q <= pg_cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_prog_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOAD && !wr_ctl_i && !load_o && ld_cnt_q == '0) |=> (phase_q == PH_PROG));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/pwt_engine.sv
// Top: page collection, timed programming and dual-plane toggle polling.
// Holds the open page address and the last accepted byte, and registers
// every read result. Reads and writes in the same cycle are handled
// independently; a read sees the state from before that edge.
module pwt_engine
    import pwt_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int LOAD_CYC   = 20,
    parameter int PROG_CYC   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctl,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              busy,
    output logic              done
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int POLL_BIT = 6;

    phase_t            seq_phase;
    logic              buf_start, buf_load, buf_clear, prog_act, seq_done;
    logic [OFF_W-1:0]  prog_idx;
    logic [DATA_W-1:0] buf_byte;
    logic              buf_vld;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] last_q;
    logic              tog_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_valid_q;
    logic              page_match, poll_hit, arr_we;
    logic [DATA_W-1:0] arr_rdata, status;

    assign page_match = (addr[ADDR_W-1:OFF_W] == page_q);
    assign poll_hit   = rd_en && (seq_phase != PH_IDLE) &&
                        (addr[ADDR_W-1] == page_q[PAGE_W-1]);
    assign arr_we     = prog_act && buf_vld;

    always_comb begin
        status           = last_q;
        status[POLL_BIT] = tog_q;
    end

    pwt_sequencer #(
        .PAGE_BYTES (PAGE_BYTES),
        .LOAD_CYC   (LOAD_CYC),
        .PROG_CYC   (PROG_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_ctl_i     (wr_ctl),
        .page_match_i (page_match),
        .phase_o      (seq_phase),
        .start_o      (buf_start),
        .load_o       (buf_load),
        .clear_o      (buf_clear),
        .prog_act_o   (prog_act),
        .prog_idx_o   (prog_idx),
        .done_o       (seq_done)
    );

    pwt_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (buf_start),
        .load_i    (buf_load),
        .clear_i   (buf_clear),
        .off_i     (addr[OFF_W-1:0]),
        .data_i    (wdata),
        .rd_idx_i  (prog_idx),
        .rd_data_o (buf_byte),
        .rd_vld_o  (buf_vld)
    );

    pwt_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i ({page_q, prog_idx}),
        .wdata_i (buf_byte),
        .raddr_i (addr),
        .rdata_o (arr_rdata)
    );

    // Page address and last accepted byte, captured on each accepted store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            last_q <= '0;
        end else begin
            if (buf_start) page_q <= addr[ADDR_W-1:OFF_W];
            if (buf_start || buf_load) last_q <= wdata;
        end
    end

    // Poll bit: cleared when a page opens, inverted by every poll.
    always_ff @(posedge clk) begin
        if (!rst_n)         tog_q <= 1'b0;
        else if (buf_start) tog_q <= 1'b0;
        else if (poll_hit)  tog_q <= ~tog_q;
    end

    // Read result register: status for the busy plane, array data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rdata_q <= poll_hit ? status : arr_rdata;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = rd_valid_q;
    assign busy     = (seq_phase != PH_IDLE);
    assign done     = seq_done;

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_abort_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == PH_LOAD && wr_ctl) |=> (!busy && !done));
    assert_buf_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == PH_PROG) |-> !(buf_start || buf_load));
    assert_array_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (seq_phase == PH_PROG));
    assert_gated_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_ctl) |=> !busy);
endmodule

// File: tb/tb_pwt_engine.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module tb_pwt_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int L  = 20;
    localparam int P  = 48;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        logic [9:0] a;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_ctl = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rd_valid, busy, done;

    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    rd_item_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwt_engine #(
        .ADDR_W (AW), .DATA_W (8), .PAGE_BYTES (32),
        .LOAD_CYC (L), .PROG_CYC (P)
    ) dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_ctl (wr_ctl),
        .rd_en (rd_en), .addr (addr), .wdata (wdata), .rdata (rdata),
        .rd_valid (rd_valid), .busy (busy), .done (done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read results in order; count done pulses.
    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected rd_valid", 1, 0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                chk(rdata === it.exp, it.tag, int'(rdata), int'(it.exp));
            end
        end
    end

    // All tasks start at a falling edge and end one cycle later.
    task automatic do_write(input logic [9:0] a, input logic [7:0] d, input logic ctl);
        wr_en = 1'b1; wr_ctl = ctl; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wr_ctl = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag; it.a = a;
        sb.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input string tag);
        int k;
        k = 0;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(done === 1'b1, tag, int'(done), 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dc;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R1 done after reset", int'(done), 0);
        chk(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);

        // R2/R3: page 0x200 (plane 1), offsets 0..7, then an overwrite.
        for (int i = 0; i < 8; i++) begin
            do_write(10'h200 + 10'(i), 8'h10 + 8'(i), 1'b0);
            if (i == 0) chk(busy === 1'b1, "R2 busy after first byte", int'(busy), 1);
        end
        idle(L - 3);
        do_write(10'h203, 8'h5A, 1'b0);
        idle(L + P - 1);
        chk(done === 1'b0 && busy === 1'b1, "R3 still programming", int'({busy, done}), 2);
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R3 done pulse due", int'({busy, done}), 1);
        @(negedge clk);
        chk(done === 1'b0, "R3 done one cycle", int'(done), 0);
        for (int i = 0; i < 8; i++)
            do_read(10'h200 + 10'(i), (i == 3) ? 8'h5A : 8'h10 + 8'(i), "R2 R4 page readback");

        // R5/R6/R7/R8: page 0x040 (plane 0) with polls and other-plane reads.
        do_write(10'h040, 8'hC3, 1'b0);
        do_write(10'h041, 8'h81, 1'b0);
        do_read(10'h05F, 8'h81, "R5 first poll bit6=0");
        do_read(10'h05F, 8'hC1, "R5 second poll bit6=1");
        do_read(10'h201, 8'h11, "R6 other plane during load");
        do_write(10'h205, 8'hEE, 1'b0);
        do_read(10'h040, 8'h81, "R7 poll after foreign-page write");
        idle(L);
        chk(busy === 1'b1, "R8 programming under way", int'(busy), 1);
        do_write(10'h041, 8'h00, 1'b0);
        do_read(10'h0A0, 8'hC1, "R8 poll during programming");
        do_read(10'h207, 8'h17, "R6 other plane during programming");
        wait_done("R3 done after page 0x040");
        do_read(10'h040, 8'hC3, "R4 programmed byte");
        do_read(10'h041, 8'h81, "R8 write during programming ignored");
        do_read(10'h205, 8'h15, "R7 foreign page unchanged");

        // R9: abort during load.
        dc = done_cnt;
        do_write(10'h041, 8'h99, 1'b0);
        do_write(10'h000, 8'h00, 1'b1);
        chk(busy === 1'b0, "R9 busy drops on abort", int'(busy), 0);
        idle(L + P + 4);
        chk(done_cnt == dc, "R9 no done after abort", done_cnt - dc, 0);
        do_read(10'h041, 8'h81, "R9 array unchanged after abort");

        // R10: strobe blocked by write control while idle.
        dc = done_cnt;
        do_write(10'h041, 8'h55, 1'b1);
        chk(busy === 1'b0, "R10 no page opened", int'(busy), 0);
        idle(L + P + 4);
        chk(done_cnt == dc, "R10 no done", done_cnt - dc, 0);
        do_read(10'h041, 8'h81, "R10 array unchanged");

        // R2/R4: full 32-byte page, then a partial rewrite of page 0x200.
        for (int i = 0; i < 32; i++) do_write(10'h0E0 + 10'(i), 8'(i) ^ 8'hA5, 1'b0);
        wait_done("R3 done after full page");
        for (int i = 0; i < 32; i++)
            do_read(10'h0E0 + 10'(i), 8'(i) ^ 8'hA5, "R2 full page readback");
        do_write(10'h202, 8'h3C, 1'b0);
        wait_done("R3 done after partial page");
        do_read(10'h202, 8'h3C, "R4 rewritten offset");
        do_read(10'h203, 8'h5A, "R4 unwritten offset kept");
        do_read(10'h207, 8'h17, "R4 unwritten offset kept");
        idle(2);
        chk(sb.size() == 0, "R11 all reads answered", sb.size(), 0);
        chk(rd_valid === 1'b0, "R11 rd_valid low when idle", int'(rd_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule